// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small accumulator-style processor. Each accepted request names one of sixteen operations and carries a first operand (the accumulator, or whichever register is compared), a second operand (an immediate or a value fetched from memory) and the current processor status byte. One clock edge later the block presents the 8-bit result and the updated status byte. Instruction decoding, the memory path and decimal-mode arithmetic are handled elsewhere.

Each operation owns a fixed subset of the status flags. It rewrites only those flags and passes every other status bit through from the incoming byte. The surrounding pipeline writes `result` back to its register file when the operation produces a value. It always writes `flags_out` back as the new status byte.

The status byte layout is: bit 0 carry (C), bit 1 zero (Z), bit 2 interrupt disable (I), bit 3 decimal (D), bit 4 break (B), bit 5 unused, bit 6 overflow (V) and bit 7 negative (N).

The `op_sel` encoding is:

| Code | Operation | Code | Operation |
|------|-----------|------|-----------|
| 0 | add with carry | 8 | rotate right |
| 1 | subtract with carry | 9 | bit test |
| 2 | AND | 10 | compare |
| 3 | OR | 11 | increment |
| 4 | XOR | 12 | decrement |
| 5 | shift left | 13 | load (pass `opnd_m`) |
| 6 | shift right | 14 | set flags |
| 7 | rotate left | 15 | clear flags |

Top module: `alu8_core`

## Requirements
- R1: After reset, `out_valid`, `result` and `flags_out` are all zero. A request accepted with `in_valid` high at a clock edge shows up on `result`, `flags_out` and `out_valid`=1 right after that same edge.
- R2: Add with carry (code 0) forms a + m + C in nine bits. The result is the low byte. C is the ninth bit. V is set when a and m have equal bit 7 and the result's bit 7 differs from a's. Z and N come from the result.
- R3: Subtract with carry (code 1) forms a + (0xFF − m) + C. C is the ninth bit. V is set when a and m differ in bit 7 and the result's bit 7 differs from a's. Z and N come from the result.
- R4: Compare (code 10) returns a unchanged. C is set when a ≥ m, unsigned. Z and N come from the 8-bit value a − m. V is left alone.
- R5: Bit test (code 9) returns a unchanged. Z is set when (a AND m) is zero. N takes m bit 7 and V takes m bit 6. C is left alone.
- R6: Shift left (code 5) puts a bit 7 into C and shifts a 0 into bit 0. Shift right (code 6) puts a bit 0 into C, shifts a 0 into bit 7 and so always clears N. Z and N come from the result.
- R7: Rotate left (code 7) and rotate right (code 8) move the incoming C into the vacated bit. The bit shifted out becomes the new C. Z and N come from the result.
- R8: AND, OR, XOR, load, increment and decrement (codes 2, 3, 4, 13, 11, 12) update only Z and N. Increment and decrement wrap modulo 256, so 0xFF+1 = 0x00 and 0x00−1 = 0xFF.
- R9: Status bits that an operation does not own pass through unchanged from `flags_in`. The decimal flag has no effect on add or subtract.
- R10: Set flags (code 14) returns `flags_in | m` and clear flags (code 15) returns `flags_in & ~m`. Both return a unchanged as the result.
- R11: While `in_valid` is low, `out_valid` falls to 0 and `result` and `flags_out` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand (accumulator or compared register) |
| opnd_m | input | 8 | Second operand, or flag mask for set/clear |
| flags_in | input | 8 | Current status byte |
| out_valid | output | 1 | Registered result is new |
| result | output | 8 | Registered result byte |
| flags_out | output | 8 | Registered updated status byte |

## Verification
Carry and overflow can both be produced in the same cycle by one add or subtract. Examples are 0x80 + 0x80, which gives 0x00 with C, V and Z set, and a signed-overflowing subtract that also leaves no borrow. These cases are driven directly. A compare of equal values raises Z and C together, and a bit test can raise N, V and Z at once.

Each case is judged against a reference model in the bench. The model rebuilds the whole status byte, so a flag that leaks into a bit it does not own fails the comparison. Requests with I, D and B set in `flags_in` show whether the pass-through bits survive alongside the simultaneous flag changes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_ASL  = 4'd5,
        OP_LSR  = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_BIT  = 4'd9,
        OP_CMP  = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12,
        OP_LOAD = 4'd13,
        OP_SETF = 4'd14,
        OP_CLRF = 4'd15
    } alu_op_e;

    localparam int ST_W  = 8;
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_I = 2;
    localparam int FLG_D = 3;
    localparam int FLG_B = 4;
    localparam int FLG_V = 6;
    localparam int FLG_N = 7;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   m,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output logic            cout,
    output logic            vout
);
    localparam int MSB = DW - 1;
    localparam logic [DW:0] ONE_X = (DW+1)'(1);

    logic [DW:0] sum_w;
    logic [DW:0] a_x;
    logic [DW:0] c_x;

    assign a_x = {1'b0, a};
    assign c_x = {{DW{1'b0}}, cin};

    always_comb begin
        sum_w = '0;
        vout  = 1'b0;
        case (op)
            OP_ADC: begin
                sum_w = a_x + {1'b0, m} + c_x;
                vout  = ~(a[MSB] ^ m[MSB]) & (a[MSB] ^ sum_w[MSB]);
            end
            OP_SBC: begin
                sum_w = a_x + {1'b0, ~m} + c_x;
                vout  = (a[MSB] ^ m[MSB]) & (a[MSB] ^ sum_w[MSB]);
            end
            OP_CMP: sum_w = a_x + {1'b0, ~m} + ONE_X;
            OP_INC: sum_w = a_x + ONE_X;
            OP_DEC: sum_w = a_x + {1'b0, {DW{1'b1}}};
            default: sum_w = a_x;
        endcase
    end

    assign res  = sum_w[DW-1:0];
    assign cout = sum_w[DW];

endmodule

// File: rtl/alu8_shlog.sv
module alu8_shlog
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   m,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output logic            cout
);
    localparam int MSB = DW - 1;

    always_comb begin
        res  = a;
        cout = cin;
        case (op)
            OP_AND:  res = a & m;
            OP_BIT:  res = a & m;
            OP_OR:   res = a | m;
            OP_XOR:  res = a ^ m;
            OP_LOAD: res = m;
            OP_ASL: begin
                res  = {a[MSB-1:0], 1'b0};
                cout = a[MSB];
            end
            OP_LSR: begin
                res  = {1'b0, a[MSB:1]};
                cout = a[0];
            end
            OP_ROL: begin
                res  = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            OP_ROR: begin
                res  = {cin, a[MSB:1]};
                cout = a[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op_sel,
    input  logic [DW-1:0]   opnd_a,
    input  logic [DW-1:0]   opnd_m,
    input  logic [ST_W-1:0] flags_in,
    output logic            out_valid,
    output logic [DW-1:0]   result,
    output logic [ST_W-1:0] flags_out
);
    localparam int MSB = DW - 1;

    typedef struct packed {
        logic            vld;
        logic [DW-1:0]   res;
        logic [ST_W-1:0] st;
    } alu_state_t;

    alu_state_t state_d, state_q;
    alu_op_e    op_w;
    logic [DW-1:0] ar_res_w, sl_res_w;
    logic          ar_c_w, ar_v_w, sl_c_w;

    assign op_w = alu_op_e'(op_sel);

    alu8_arith #(.DW(DW)) u_arith (
        .op  (op_w),
        .a   (opnd_a),
        .m   (opnd_m),
        .cin (flags_in[FLG_C]),
        .res (ar_res_w),
        .cout(ar_c_w),
        .vout(ar_v_w)
    );

    alu8_shlog #(.DW(DW)) u_shlog (
        .op  (op_w),
        .a   (opnd_a),
        .m   (opnd_m),
        .cin (flags_in[FLG_C]),
        .res (sl_res_w),
        .cout(sl_c_w)
    );

    function automatic logic [ST_W-1:0] put_zn(input logic [ST_W-1:0] s,
                                                input logic [DW-1:0] v);
        logic [ST_W-1:0] t;
        t        = s;
        t[FLG_Z] = (v == '0);
        t[FLG_N] = v[MSB];
        return t;
    endfunction

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = opnd_a;
            state_d.st  = flags_in;
            case (op_w)
                OP_ADC, OP_SBC: begin
                    state_d.res       = ar_res_w;
                    state_d.st        = put_zn(flags_in, ar_res_w);
                    state_d.st[FLG_C] = ar_c_w;
                    state_d.st[FLG_V] = ar_v_w;
                end
                OP_CMP: begin
                    state_d.st        = put_zn(flags_in, ar_res_w);
                    state_d.st[FLG_C] = ar_c_w;
                end
                OP_INC, OP_DEC: begin
                    state_d.res = ar_res_w;
                    state_d.st  = put_zn(flags_in, ar_res_w);
                end
                OP_AND, OP_OR, OP_XOR, OP_LOAD: begin
                    state_d.res = sl_res_w;
                    state_d.st  = put_zn(flags_in, sl_res_w);
                end
                OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                    state_d.res       = sl_res_w;
                    state_d.st        = put_zn(flags_in, sl_res_w);
                    state_d.st[FLG_C] = sl_c_w;
                    if (op_w == OP_LSR) state_d.st[FLG_N] = 1'b0;
                end
                OP_BIT: begin
                    state_d.st[FLG_Z] = (sl_res_w == '0);
                    state_d.st[FLG_N] = opnd_m[MSB];
                    state_d.st[FLG_V] = opnd_m[MSB-1];
                end
                OP_SETF: state_d.st = flags_in | ST_W'(opnd_m);
                OP_CLRF: state_d.st = flags_in & ~ST_W'(opnd_m);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
    assign flags_out = state_q.st;

    // R1: one-cycle latency of the valid marker
    a_r1_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11: outputs hold while idle
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out)));

    a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_w != OP_SETF && op_w != OP_CLRF)
        |=> flags_out[5:2] == $past(flags_in[5:2]));

    a_r4_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_w == OP_CMP)
        |=> (flags_out[FLG_C] == ($past(opnd_a) >= $past(opnd_m))) && result == $past(opnd_a));

    a_r5_bit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_w == OP_BIT)
        |=> (flags_out[7:6] == $past(opnd_m[MSB:MSB-1])) && result == $past(opnd_a));

    a_r6_lsr_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_w == OP_LSR) |=> !flags_out[FLG_N]);

    a_r8_cv_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_w == OP_AND || op_w == OP_OR || op_w == OP_XOR ||
                      op_w == OP_LOAD || op_w == OP_INC || op_w == OP_DEC))
        |=> (flags_out[FLG_C] == $past(flags_in[FLG_C]) &&
             flags_out[FLG_V] == $past(flags_in[FLG_V])));

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_m = '0;
    logic [7:0] flags_in = '0;
    logic       out_valid;
    logic [7:0] result;
    logic [7:0] flags_out;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  last_res = '0;
    logic [7:0]  last_st = '0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core u_alu8_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_m(opnd_m), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .flags_out(flags_out)
    );

    function automatic logic [15:0] ref_model(int op, int a, int m, int st);
        int r, s, c, v, zsrc;
        int own;
        r = a; s = st; c = st & 1; v = 0; zsrc = a; own = 0;
        case (op)
            0: begin s = a + m + c; r = s & 255; c = (s > 255);
                v = (((a ^ m) & 128) == 0) && (((a ^ r) & 128) != 0);
                zsrc = r; own = 8'hC3; end
            1: begin s = a + (255 - m) + c; r = s & 255; c = (s > 255);
                v = (((a ^ m) & 128) != 0) && (((a ^ r) & 128) != 0);
                zsrc = r; own = 8'hC3; end
            2: begin r = a & m; zsrc = r; own = 8'h82; end
            3: begin r = a | m; zsrc = r; own = 8'h82; end
            4: begin r = a ^ m; zsrc = r; own = 8'h82; end
            5: begin r = (a * 2) & 255; c = a / 128; zsrc = r; own = 8'h83; end
            6: begin r = a / 2; c = a % 2; zsrc = r; own = 8'h83; end
            7: begin r = ((a * 2) & 255) + c; c = a / 128; zsrc = r; own = 8'h83; end
            8: begin r = (a / 2) + c * 128; c = a % 2; zsrc = r; own = 8'h83; end
            9: begin r = a; zsrc = a & m; own = 8'hC2; v = (m / 64) % 2; end
            10: begin r = a; c = (a >= m); zsrc = (a - m) & 255; own = 8'h83; end
            11: begin r = (a + 1) % 256; zsrc = r; own = 8'h82; end
            12: begin r = (a + 255) % 256; zsrc = r; own = 8'h82; end
            13: begin r = m; zsrc = r; own = 8'h82; end
            14: return {a[7:0], 8'((st | m) & 255)};
            default: return {a[7:0], 8'(st & ~m & 255)};
        endcase
        s = st & ~own & 255;
        if ((own & 1) != 0 && c != 0) s = s | 1;
        if (zsrc == 0) s = s | 2;
        if ((own & 64) != 0 && v != 0) s = s | 64;
        if (op == 9) begin
            if (m >= 128) s = s | 128;
        end else if ((zsrc & 128) != 0) s = s | 128;
        return {r[7:0], s[7:0]};
    endfunction

    function automatic string req_of(int op);
        case (op)
            0: return "R2";
            1: return "R3";
            10: return "R4";
            9: return "R5";
            5, 6: return "R6";
            7, 8: return "R7";
            14, 15: return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic send(input int op, input int a, input int m, input int st,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_sel   = 4'(op);
        opnd_a   = 8'(a);
        opnd_m   = 8'(m);
        flags_in = 8'(st);
        exp_q.push_back(ref_model(op, a, m, st));
        tag_q.push_back(tag == "" ? req_of(op) : tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_sel   = 4'($urandom % 16);
            opnd_a   = 8'($urandom % 256);
            opnd_m   = 8'($urandom % 256);
            flags_in = 8'($urandom % 256);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                logic [15:0] e;
                string t;
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R1 unexpected out_valid result=%02h flags=%02h expected no output",
                             result, flags_out);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (result !== e[15:8] || flags_out !== e[7:0]) begin
                        failures++;
                        $display("FAIL %s result=%02h flags=%02h expected result=%02h flags=%02h",
                                 t, result, flags_out, e[15:8], e[7:0]);
                    end
                end
                last_res = result;
                last_st  = flags_out;
            end else begin
                checks++;
                if (result !== last_res || flags_out !== last_st) begin
                    failures++;
                    $display("FAIL R11 idle result=%02h flags=%02h expected result=%02h flags=%02h",
                             result, flags_out, last_res, last_st);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || result !== 8'h00 || flags_out !== 8'h00) begin
            failures++;
            $display("FAIL R1 reset valid=%0b result=%02h flags=%02h expected 0/00/00",
                     out_valid, result, flags_out);
        end
        // R2 corners: signed overflow, carry-out with zero, carry+overflow together
        send(0, 8'h7F, 8'h01, 8'h00, "R2");
        send(0, 8'hFF, 8'h01, 8'h00, "R2");
        send(0, 8'h80, 8'h80, 8'h00, "R2");
        send(0, 8'h10, 8'h20, 8'h01, "R2");
        // R9: decimal flag set has no effect on add/subtract; I and B pass
        send(0, 8'h09, 8'h01, 8'h1C, "R9");
        send(1, 8'h10, 8'h01, 8'h1D, "R9");
        // R3
        send(1, 8'h50, 8'hB0, 8'h01, "R3");
        send(1, 8'h80, 8'h01, 8'h01, "R3");
        send(1, 8'h00, 8'h01, 8'h01, "R3");
        send(1, 8'h05, 8'h05, 8'h00, "R3");
        // R4: equal, less, greater
        send(10, 8'h42, 8'h42, 8'h40, "R4");
        send(10, 8'h10, 8'h20, 8'h00, "R4");
        send(10, 8'hF0, 8'h01, 8'h41, "R4");
        // R5
        send(9, 8'h00, 8'hC0, 8'h01, "R5");
        send(9, 8'h0F, 8'h41, 8'hC0, "R5");
        // R6
        send(5, 8'h81, 8'h00, 8'h00, "R6");
        send(6, 8'h01, 8'h00, 8'h80, "R6");
        // R7 through carry
        send(7, 8'h80, 8'h00, 8'h00, "R7");
        send(7, 8'h40, 8'h00, 8'h01, "R7");
        send(8, 8'h01, 8'h00, 8'h00, "R7");
        send(8, 8'h02, 8'h00, 8'h01, "R7");
        // R8 wrap and Z/N only
        send(11, 8'hFF, 8'h00, 8'h41, "R8");
        send(12, 8'h00, 8'h00, 8'h41, "R8");
        send(2, 8'hF0, 8'h0F, 8'h7D, "R8");
        send(13, 8'h00, 8'h80, 8'h00, "R8");
        // R10
        send(14, 8'h33, 8'h49, 8'h02, "R10");
        send(15, 8'h33, 8'h41, 8'hFF, "R10");
        // R11 hold while idle with garbage inputs
        idle(4);
        for (int i = 0; i < 400; i++) begin
            send($urandom % 16, $urandom % 256, $urandom % 256, $urandom % 256, "");
            if (i % 37 == 0) idle(2);
        end
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R1 pending=%0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule